// File: doc/BRIEF.md
# Core power-down and timed soft-reset controller

This block is the global power and reset control of a register-configured device. It holds two small control registers behind a single-cycle register port. From those registers and two pins it works out three things: whether the digital core may be clocked, whether the core is held in reset, and which of three data converters are powered down. The core clock is modelled as a registered enable, so it only changes on a clock edge. The register port keeps working while the core is frozen.

Core power-down can be requested by an external pin or by a register bit. A priority-select bit decides which of the two is obeyed, and the other one is ignored. A soft reset can be started in two ways: by writing the self-clearing reset bit, or by the external reset-request pin. The soft reset lasts a parameterised number of cycles. At its start it reloads every register bit that has a defined default. Bits without a default keep their contents. The write that starts the reset receives no acknowledge. While the sequence runs, writes are refused and reads are still answered.

Both pins are asynchronous to the clock. Each passes through a synchronizer before it is used.

Top module: `pwr_rst_ctl`

## Requirements
- R1: After `rst_ni` is released with both pins low, the outputs are as follows. `bus_ack_o`, `busy_o` and `conv_pd_o` are 0. `core_clk_en_o` and `core_rst_no` are 1. Both registers read 0x00.
- R2: The control register is at address 0x0. It holds the priority select in bit 2, the power-down request in bit 5 and the reset command in bit 7. The converter register is at address 0x1. A read or write is acknowledged by `bus_ack_o` high for one cycle, one cycle after the request. For a read, `bus_rdata_o` is valid in that same cycle. Unmapped addresses read 0x00. When read and write are both asserted, the write is taken.
- R3: With priority select at 0, the power-down request bit is ignored. `core_clk_en_o` equals the inverse of `pd_pin_i`, three clock edges after the pin changes.
- R4: With priority select at 1, `pd_pin_i` is ignored. `core_clk_en_o` equals the inverse of the power-down request bit, two edges after the accepted write.
- R5: While the core is powered down, register reads and writes are still accepted and acknowledged. Register contents are not altered by power-down.
- R6: Writing 1 to control bit 7 while idle starts the reset sequence, and that write is not acknowledged. `busy_o` is high for exactly `RST_CYCLES` cycles. Control bit 7 reads 1 while `busy_o` is high and 0 afterwards.
- R7: At the start of a reset sequence, control bits 2, 5 and 7's defaults are loaded: bits 2 and 5 go to 0. Converter bits 3, 2 and 1 go to 0. The bits without defaults keep their previous contents: control bits 0, 1, 3, 4 and 6, and converter bits 0 and 4 to 7. The other fields of the triggering write are discarded.
- R8: While `busy_o` is high, writes are ignored and not acknowledged, and reads are acknowledged.
- R9: `ext_rst_i`, once synchronized, starts the same reset sequence as control bit 7 when the block is idle.
- R10: While `busy_o` is high, `core_rst_no` is 0 and `core_clk_en_o` is 1. After the sequence, power-down follows the reloaded defaults.
- R11: Converter register bits 3, 2 and 1 drive `conv_pd_o[0]`, `conv_pd_o[1]` and `conv_pd_o[2]` independently. A value of 1 means the converter is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pd_pin_i | input | 1 | External core power-down request, asynchronous |
| ext_rst_i | input | 1 | External soft-reset request, asynchronous, active high |
| bus_wr_i | input | 1 | Register write strobe, one cycle per transfer |
| bus_rd_i | input | 1 | Register read strobe, one cycle per transfer |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with the acknowledge |
| bus_ack_o | output | 1 | Transfer acknowledge; stays low for a refused transfer |
| busy_o | output | 1 | Reset sequence in progress |
| core_clk_en_o | output | 1 | Registered digital-core clock enable |
| core_rst_no | output | 1 | Digital-core reset, active low |
| conv_pd_o | output | 3 | Per-converter power-down |

## Verification
The properties assume that the register strobes are single-cycle pulses that are sampled at the clock edge. They also assume that the pins are held long enough to pass the synchronizer. On that basis they relate the reset command bit, `busy_o`, the acknowledge and the converter outputs over time. The bench changes every input half a period away from the active edge. It holds `ext_rst_i` high for three cycles, so that it is certain to be synchronized. It waits for the full synchronizer and enable latency before it samples a power-down effect.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

  localparam int BUS_AW = 4;
  localparam int BUS_DW = 8;
  localparam int N_CONV = 3;

  localparam logic [BUS_AW-1:0] ADDR_CTRL = 4'h0;
  localparam logic [BUS_AW-1:0] ADDR_CONV = 4'h1;

  localparam int BIT_PRIO = 2;
  localparam int BIT_PD   = 5;
  localparam int BIT_RST  = 7;
  localparam int BIT_CONV0 = 3;

  localparam logic [BUS_DW-1:0] CTRL_DEF_MASK = 8'hA4;
  localparam logic [BUS_DW-1:0] CTRL_DEF_VAL  = 8'h00;
  localparam logic [BUS_DW-1:0] CONV_DEF_MASK = 8'h0E;
  localparam logic [BUS_DW-1:0] CONV_DEF_VAL  = 8'h00;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } bus_req_t;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int RST_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  input  logic hw_req_i,
  output logic start_o,
  output logic done_o,
  output logic busy_o
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign start_o = !busy_q && (sw_req_i || hw_req_i);
  assign done_o  = busy_q && (cnt_q == '0);
  assign cnt_en  = start_o || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_o) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_rst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_req_t          req_i,
  input  logic              busy_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              rst_wr_o,
  output logic [BUS_DW-1:0] ctrl_o,
  output logic [BUS_DW-1:0] conv_o,
  output logic              ack_o,
  output logic [BUS_DW-1:0] rdata_o
);

  logic [BUS_DW-1:0] ctrl_q, ctrl_d;
  logic [BUS_DW-1:0] conv_q, conv_d;
  logic [BUS_DW-1:0] rdata_q, rdata_d;
  logic              ack_q, ack_d;
  logic              wr_ok, rd_ok;
  logic [BUS_DW-1:0] rd_mux;

  assign rst_wr_o = req_i.wr && !busy_i && (req_i.addr == ADDR_CTRL)
                    && req_i.data[BIT_RST];
  assign wr_ok    = req_i.wr && !busy_i && !start_i;
  assign rd_ok    = req_i.rd && !req_i.wr;

  always_comb begin
    unique case (req_i.addr)
      ADDR_CTRL: rd_mux = ctrl_q;
      ADDR_CONV: rd_mux = conv_q;
      default:   rd_mux = '0;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    conv_d  = conv_q;
    rdata_d = rdata_q;
    ack_d   = 1'b0;
    if (start_i) begin
      ctrl_d = (ctrl_q & ~CTRL_DEF_MASK) | (CTRL_DEF_VAL & CTRL_DEF_MASK);
      ctrl_d[BIT_RST] = 1'b1;
      conv_d = (conv_q & ~CONV_DEF_MASK) | (CONV_DEF_VAL & CONV_DEF_MASK);
    end else if (done_i) begin
      ctrl_d[BIT_RST] = 1'b0;
    end else if (wr_ok) begin
      if (req_i.addr == ADDR_CTRL) ctrl_d = req_i.data;
      if (req_i.addr == ADDR_CONV) conv_d = req_i.data;
    end
    if (wr_ok) begin
      ack_d = 1'b1;
    end else if (rd_ok) begin
      ack_d   = 1'b1;
      rdata_d = rd_mux;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      conv_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      conv_q  <= conv_d;
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign conv_o  = conv_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/pwr_gate.sv
module pwr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prio_bit_i,
  input  logic pd_bit_i,
  input  logic pd_pin_sync_i,
  input  logic start_i,
  input  logic busy_i,
  output logic pd_eff_o,
  output logic clk_en_o
);

  logic en_q, en_d;

  assign pd_eff_o = prio_bit_i ? pd_bit_i : pd_pin_sync_i;

  always_comb begin
    en_d = !pd_eff_o;
    if (start_i || busy_i) en_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_d;
  end

  assign clk_en_o = en_q;

endmodule

// File: rtl/pwr_rst_ctl.sv
module pwr_rst_ctl
  import pwr_rst_pkg::*;
#(
  parameter int RST_CYCLES  = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_pin_i,
  input  logic              ext_rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              bus_ack_o,
  output logic              busy_o,
  output logic              core_clk_en_o,
  output logic              core_rst_no,
  output logic [N_CONV-1:0] conv_pd_o
);

  bus_req_t          req;
  logic [1:0]        pins_sync;
  logic              start, done, busy, rst_wr, pd_eff;
  logic [BUS_DW-1:0] ctrl_w, conv_w;
  logic              prio_w, pdbit_w, rstbit_w;

  assign req.wr   = bus_wr_i;
  assign req.rd   = bus_rd_i;
  assign req.addr = bus_addr_i;
  assign req.data = bus_wdata_i;

  pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ext_rst_i, pd_pin_i}),
    .sync_o  (pins_sync)
  );

  pwr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_req_i (rst_wr),
    .hw_req_i (pins_sync[1]),
    .start_o  (start),
    .done_o   (done),
    .busy_o   (busy)
  );

  pwr_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .busy_i   (busy),
    .start_i  (start),
    .done_i   (done),
    .rst_wr_o (rst_wr),
    .ctrl_o   (ctrl_w),
    .conv_o   (conv_w),
    .ack_o    (bus_ack_o),
    .rdata_o  (bus_rdata_o)
  );

  assign prio_w   = ctrl_w[BIT_PRIO];
  assign pdbit_w  = ctrl_w[BIT_PD];
  assign rstbit_w = ctrl_w[BIT_RST];

  pwr_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .prio_bit_i    (prio_w),
    .pd_bit_i      (pdbit_w),
    .pd_pin_sync_i (pins_sync[0]),
    .start_i       (start),
    .busy_i        (busy),
    .pd_eff_o      (pd_eff),
    .clk_en_o      (core_clk_en_o)
  );

  genvar c;
  generate
    for (c = 0; c < N_CONV; c++) begin : g_conv
      assign conv_pd_o[c] = conv_w[BIT_CONV0 - c];
    end
  endgenerate

  assign busy_o      = busy;
  assign core_rst_no = !busy;

  logic unused_pd_eff;
  assign unused_pd_eff = pd_eff;

endmodule

// File: rtl/pwr_rst_ctl_chk.sv
module pwr_rst_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_wr_i,
  input logic       bus_ack_o,
  input logic       busy_o,
  input logic       core_clk_en_o,
  input logic       prio_w,
  input logic       pdbit_w,
  input logic       rstbit_w,
  input logic [2:0] conv_pd_o
);

  // R8: a write issued during the sequence never gets an acknowledge
  a_r8_busy_write_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && busy_o) |=> !bus_ack_o);

  // R6: the reset command bit reads 1 exactly while the sequence runs
  a_r6_bit_tracks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstbit_w == busy_o);

  // R6: the bit has cleared itself once the sequence is over
  a_r6_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !rstbit_w);

  // R7: defaults are in place as soon as the sequence begins
  a_r7_defaults_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!prio_w && !pdbit_w && conv_pd_o == 3'b000));

  // R10: the core is clocked throughout the sequence
  a_r10_clock_on_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> core_clk_en_o);

  // R5: converter outputs only move on a write or a reset sequence
  a_r5_conv_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bus_wr_i) && !$past(busy_o) && !busy_o) |-> $stable(conv_pd_o));

endmodule

bind pwr_rst_ctl pwr_rst_ctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_ack_o     (bus_ack_o),
  .busy_o        (busy_o),
  .core_clk_en_o (core_clk_en_o),
  .prio_w        (prio_w),
  .pdbit_w       (pdbit_w),
  .rstbit_w      (rstbit_w),
  .conv_pd_o     (conv_pd_o)
);

// File: tb/pwr_rst_ctl_tb.sv
`timescale 1ns/1ps
module pwr_rst_ctl_tb_top;

  localparam int N = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       pd_pin_i, ext_rst_i;
  logic       bus_wr_i, bus_rd_i;
  logic [3:0] bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       bus_ack_o, busy_o, core_clk_en_o, core_rst_no;
  logic [2:0] conv_pd_o;

  int checks = 0;
  int errors = 0;
  int busy_cycles = 0;

  always #10 clk_i = ~clk_i;

  pwr_rst_ctl #(.RST_CYCLES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_pin_i(pd_pin_i), .ext_rst_i(ext_rst_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_ack_o(bus_ack_o),
    .busy_o(busy_o), .core_clk_en_o(core_clk_en_o), .core_rst_no(core_rst_no),
    .conv_pd_o(conv_pd_o)
  );

  always @(negedge clk_i) if (busy_o === 1'b1) busy_cycles++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, output logic ack);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    ack = bus_ack_o;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d, output logic ack);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    d = bus_rdata_o; ack = bus_ack_o;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic a;
    chk("R1 ack", bus_ack_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 clk_en", core_clk_en_o, 1);
    chk("R1 core_rst_n", core_rst_no, 1);
    chk("R1 conv_pd", conv_pd_o, 0);
    bus_read(4'h0, d, a); chk("R1 ctrl", d, 8'h00);
    bus_read(4'h1, d, a); chk("R1 conv", d, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] d; logic a;
    bus_write(4'h1, 8'h04, a); chk("R2 write ack", a, 1);
    chk("R11 conv1 only", conv_pd_o, 3'b010);
    bus_read(4'h1, d, a); chk("R2 read ack", a, 1); chk("R2 read data", d, 8'h04);
    bus_read(4'h9, d, a); chk("R2 unmapped", d, 8'h00);
    bus_write(4'h1, 8'h08, a); chk("R11 conv0 only", conv_pd_o, 3'b001);
    bus_write(4'h1, 8'h02, a); chk("R11 conv2 only", conv_pd_o, 3'b100);
    cyc(1); chk("R2 ack single cycle", bus_ack_o, 0);
    bus_write(4'h1, 8'h00, a);
  endtask

  task automatic t_pin_prio();
    logic a;
    bus_write(4'h0, 8'h20, a); cyc(3);
    chk("R3 bit ignored", core_clk_en_o, 1);
    pd_pin_i = 1'b1; cyc(2); chk("R3 not yet", core_clk_en_o, 1);
    cyc(1); chk("R3 pin powers down", core_clk_en_o, 0);
    pd_pin_i = 1'b0; cyc(3); chk("R3 pin releases", core_clk_en_o, 1);
  endtask

  task automatic t_bit_prio();
    logic a;
    bus_write(4'h0, 8'h04, a); pd_pin_i = 1'b1; cyc(4);
    chk("R4 pin ignored", core_clk_en_o, 1);
    bus_write(4'h0, 8'h24, a); cyc(1);
    chk("R4 bit powers down", core_clk_en_o, 0);
    bus_write(4'h0, 8'h04, a); cyc(1);
    chk("R4 bit releases", core_clk_en_o, 1);
    pd_pin_i = 1'b0; cyc(3);
  endtask

  task automatic t_retention();
    logic [7:0] d; logic a;
    bus_write(4'h0, 8'h24, a); cyc(1);
    chk("R5 powered down", core_clk_en_o, 0);
    bus_write(4'h1, 8'h0A, a); chk("R5 write ack while down", a, 1);
    chk("R5 conv out", conv_pd_o, 3'b101);
    bus_read(4'h1, d, a); chk("R5 read ack while down", a, 1);
    chk("R5 conv kept", d, 8'h0A);
    bus_read(4'h0, d, a); chk("R5 ctrl kept", d, 8'h24);
    bus_write(4'h0, 8'h04, a); cyc(1);
    chk("R5 leave by bit", core_clk_en_o, 1);
    bus_read(4'h1, d, a); chk("R5 conv after", d, 8'h0A);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d; logic a;
    bus_write(4'h0, 8'h7F, a);
    bus_write(4'h1, 8'hFF, a); cyc(1);
    chk("R4 down before reset", core_clk_en_o, 0);
    busy_cycles = 0;
    bus_write(4'h0, 8'h80, a);
    chk("R6 trigger nack", a, 0);
    chk("R6 busy", busy_o, 1);
    chk("R10 core reset", core_rst_no, 0);
    chk("R10 clock on", core_clk_en_o, 1);
    chk("R7 conv defaults", conv_pd_o, 3'b000);
    bus_write(4'h1, 8'h00, a); chk("R8 busy write nack", a, 0);
    bus_read(4'h0, d, a); chk("R8 busy read ack", a, 1);
    chk("R6 bit reads 1", d, 8'hDB);
    wait_idle();
    chk("R6 busy length", busy_cycles, N);
    chk("R10 core reset released", core_rst_no, 1);
    bus_read(4'h0, d, a); chk("R7 ctrl scratch kept", d, 8'h5B);
    bus_read(4'h1, d, a); chk("R7 conv scratch kept R8", d, 8'hF1);
    cyc(1); chk("R10 powered up after", core_clk_en_o, 1);
  endtask

  task automatic t_ext_reset();
    logic [7:0] d; logic a;
    bus_write(4'h0, 8'h25, a); cyc(1);
    chk("R4 down before ext", core_clk_en_o, 0);
    busy_cycles = 0;
    ext_rst_i = 1'b1; cyc(3); ext_rst_i = 1'b0;
    chk("R9 ext started", busy_o, 1);
    chk("R10 clock on ext", core_clk_en_o, 1);
    wait_idle();
    chk("R9 busy length", busy_cycles, N);
    bus_read(4'h0, d, a); chk("R9 ctrl after", d, 8'h01);
    cyc(4); chk("R9 no restart", busy_o, 0);
    chk("R10 up after ext", core_clk_en_o, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pd_pin_i = 1'b0; ext_rst_i = 1'b0;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_rw();
    t_pin_prio();
    t_bit_prio();
    t_retention();
    t_soft_reset();
    t_ext_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule